// File: doc/BRIEF.md
# Configurable IRQ Sense Status Register

This block collects six external interrupt request pins into one 8-bit status register. Each pin has its own 2-bit sense selection, which picks one of four trigger conditions: low level, falling edge, rising edge, or either edge. When the selected condition is seen on a synchronized copy of the pin, the matching flag is latched. Each flag is also presented as a request line to the interrupt controller.

Software clears flags through a simple read/write register port. A write of 0 takes effect on a flag only if an earlier read of the register returned that flag as 1, and no other write came in between.

Hardware also clears flags:
- A per-line service acknowledge clears the flag. In edge modes this always happens. In level mode it happens only if the pin is high at that moment.
- A per-line transfer acknowledge clears the flag, but only while the transfer-disable level is low.

A hardware standby input clears everything, just as reset does.

Top module: `irq_sense_status`

## Requirements
- R1: `reg_rdata` bits 5..0 show the flags of lines 5..0 (bit n for line n), and bits 7..6 always read 0.
- R2: Synchronous reset, or `hw_standby` high at a clock edge, makes all flags 0.
- R3: With sense code 2'b00 (bits {2n+1,2n} of `sense_sel` for line n), the flag sets while the synchronized pin is low. A pin change is visible in the flag at the third rising clock edge after it is applied.
- R4: Sense code 2'b01 sets the flag on a high-to-low transition only. A low-to-high transition leaves it untouched.
- R5: Sense code 2'b10 sets the flag on a low-to-high transition only. A high-to-low transition leaves it untouched.
- R6: Sense code 2'b11 sets the flag on either transition.
- R7: Writing 1 to a flag bit never changes that flag.
- R8: Writing 0 to a flag bit clears it only if that bit was read as 1 by a read after the most recent write. Any write removes that permission for every bit.
- R9: In any edge mode (codes 01, 10, 11), `svc_ack[n]` clears flag n at the next edge.
- R10: In level mode, `svc_ack[n]` clears flag n only when the synchronized pin n is high.
- R11: `xfer_ack[n]` clears flag n when `xfer_dis` is 0 and has no effect when `xfer_dis` is 1.
- R12: When a set condition and any clear condition hit the same flag in the same cycle, the flag ends up 1.
- R13: `irq_req[n]` equals flag n at all times.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_standby | input | 1 | Clears all flags while high |
| irq_pin | input | 6 | Asynchronous interrupt request pins |
| sense_sel | input | 12 | Two sense-code bits per line, line n at bits 2n+1..2n |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data; a 0 bit requests a clear |
| reg_rdata | output | 8 | Register read value |
| svc_ack | input | 6 | Per-line exception-service acknowledge |
| xfer_ack | input | 6 | Per-line transfer-controller acknowledge |
| xfer_dis | input | 1 | Disable-select level sent with a transfer acknowledge |
| irq_req | output | 6 | Per-line request to the interrupt controller |

## Verification
The bench checks the exact latency of the synchronizer and edge detector by sampling one edge before the flag is due and again at the edge where it is due. A design with a missing or extra stage fails one of the two checks.

The clear handshake gets its own tests:
- a write of 0 with no prior read;
- a write of 1 after a read;
- a read that is followed by an unrelated write.

A design that ignores the read record, or keeps it across writes, would clear the flag in one of these cases.

The bench also tests several acknowledge cases:
- a service acknowledge in level mode while the pin is still low, then again after the pin returns high;
- a transfer acknowledge with the disable level high;
- an acknowledge that lands in the same cycle as a new edge.

A design that gives clear priority over set drops that edge.

// File: rtl/irqss_pkg.sv
package irqss_pkg;

    localparam int IRQSS_LINES  = 6;
    localparam int IRQSS_REG_W  = 8;
    localparam int IRQSS_SEL_W  = 2;
    localparam int IRQSS_STAGES = 2;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef struct packed {
        logic level;
        logic fell;
        logic rose;
    } pin_obs_t;

    function automatic logic sense_hit(sense_e mode, pin_obs_t obs);
        logic hit;
        case (mode)
            SENSE_LOW:  hit = ~obs.level;
            SENSE_FALL: hit = obs.fell;
            SENSE_RISE: hit = obs.rose;
            default:    hit = obs.fell | obs.rose;
        endcase
        return hit;
    endfunction

    function automatic logic is_edge_mode(sense_e mode);
        return mode != SENSE_LOW;
    endfunction

endpackage

// File: rtl/irqss_sync.sv
module irqss_sync
    import irqss_pkg::*;
#(
    parameter int   STAGES = IRQSS_STAGES,
    parameter logic IDLE   = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output pin_obs_t obs
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{IDLE}};
            prev  <= IDLE;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    always_comb begin
        obs.level = chain[STAGES-1];
        obs.fell  = prev & ~chain[STAGES-1];
        obs.rose  = ~prev & chain[STAGES-1];
    end
endmodule

// File: rtl/irqss_flag.sv
module irqss_flag (
    input  logic clk,
    input  logic rst,
    input  logic wipe,
    input  logic set_hit,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst || wipe)
            flag <= 1'b0;
        else if (set_hit)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end
endmodule

// File: rtl/irqss_regif.sv
module irqss_regif
    import irqss_pkg::*;
#(
    parameter int NLINES = IRQSS_LINES,
    parameter int REG_W  = IRQSS_REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [NLINES-1:0] flags,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NLINES-1:0] sw_clr
);
    logic [NLINES-1:0] seen_one;
    logic              unused_hi;

    always_ff @(posedge clk) begin
        if (rst || wipe)
            seen_one <= '0;
        else if (reg_wr)
            seen_one <= '0;
        else if (reg_rd)
            seen_one <= flags;
    end

    assign reg_rdata = REG_W'(flags);
    assign unused_hi = ^reg_wdata[REG_W-1:NLINES];

    always_comb begin
        for (int i = 0; i < NLINES; i++)
            sw_clr[i] = reg_wr & ~reg_wdata[i] & seen_one[i];
    end
endmodule

// File: rtl/irq_sense_status.sv
module irq_sense_status
    import irqss_pkg::*;
#(
    parameter int NLINES = IRQSS_LINES,
    parameter int REG_W  = IRQSS_REG_W,
    parameter int STAGES = IRQSS_STAGES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          hw_standby,
    input  logic [NLINES-1:0]             irq_pin,
    input  logic [NLINES*IRQSS_SEL_W-1:0] sense_sel,
    input  logic                          reg_rd,
    input  logic                          reg_wr,
    input  logic [REG_W-1:0]              reg_wdata,
    output logic [REG_W-1:0]              reg_rdata,
    input  logic [NLINES-1:0]             svc_ack,
    input  logic [NLINES-1:0]             xfer_ack,
    input  logic                          xfer_dis,
    output logic [NLINES-1:0]             irq_req
);
    localparam int SW = IRQSS_SEL_W;

    logic [NLINES-1:0] flags;
    logic [NLINES-1:0] sw_clr;

    irqss_regif #(.NLINES(NLINES), .REG_W(REG_W)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .wipe      (hw_standby),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .flags     (flags),
        .reg_rdata (reg_rdata),
        .sw_clr    (sw_clr)
    );

    for (genvar n = 0; n < NLINES; n++) begin : g_line
        pin_obs_t obs;
        sense_e   mode;
        logic     hit;
        logic     hw_clr;

        irqss_sync #(.STAGES(STAGES), .IDLE(1'b1)) u_sync (
            .clk (clk),
            .rst (rst),
            .pin (irq_pin[n]),
            .obs (obs)
        );

        always_comb begin
            mode   = sense_e'(sense_sel[n*SW +: SW]);
            hit    = sense_hit(mode, obs);
            hw_clr = (svc_ack[n] & (is_edge_mode(mode) | obs.level))
                   | (xfer_ack[n] & ~xfer_dis);
        end

        irqss_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .wipe    (hw_standby),
            .set_hit (hit),
            .clr_req (hw_clr | sw_clr[n]),
            .flag    (flags[n])
        );
    end

    assign irq_req = flags;
endmodule

// File: rtl/irqss_checker.sv
module irqss_checker #(
    parameter int NLINES = 6,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              hw_standby,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [NLINES-1:0] svc_ack,
    input logic [NLINES-1:0] xfer_ack,
    input logic              xfer_dis,
    input logic [NLINES-1:0] irq_req
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1:NLINES] == '0);

    a_r13_req_mirrors: assert property (@(posedge clk) disable iff (rst)
        irq_req == reg_rdata[NLINES-1:0]);

    a_r2_standby_wipes: assert property (@(posedge clk) disable iff (rst)
        hw_standby |=> irq_req == '0);

    for (genvar n = 0; n < NLINES; n++) begin : g_chk
        a_r7_one_keeps: assert property (@(posedge clk) disable iff (rst)
            (irq_req[n] && reg_wr && reg_wdata[n] && !svc_ack[n]
             && !(xfer_ack[n] && !xfer_dis) && !hw_standby) |=> irq_req[n]);

        a_r8_fall_has_cause: assert property (@(posedge clk) disable iff (rst)
            $fell(irq_req[n]) |-> $past(reg_wr || svc_ack[n]
                || (xfer_ack[n] && !xfer_dis) || hw_standby));
    end
endmodule

bind irq_sense_status irqss_checker #(.NLINES(NLINES), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hw_standby (hw_standby),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .svc_ack    (svc_ack),
    .xfer_ack   (xfer_ack),
    .xfer_dis   (xfer_dis),
    .irq_req    (irq_req)
);

// File: tb/sim_irq_sense_status.sv
`timescale 1ns/1ps
module sim_irq_sense_status;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_standby = 1'b0;
    logic [5:0]  irq_pin = 6'h3F;
    logic [11:0] sense_sel;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'hFF;
    logic [7:0]  reg_rdata;
    logic [5:0]  svc_ack = '0;
    logic [5:0]  xfer_ack = '0;
    logic        xfer_dis = 1'b0;
    logic [5:0]  irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_sense_status u0 (
        .clk(clk), .rst(rst), .hw_standby(hw_standby), .irq_pin(irq_pin),
        .sense_sel(sense_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .svc_ack(svc_ack),
        .xfer_ack(xfer_ack), .xfer_dis(xfer_dis), .irq_req(irq_req)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_flag(int n, bit exp, string req, string what);
        chk(reg_rdata[n] == exp && irq_req[n] == exp, req, what,
            int'(reg_rdata[n]), int'(exp));
    endtask

    task automatic t_reset();
        chk(reg_rdata == 8'h00, "R2", "reset rdata", reg_rdata, 0);
        chk(irq_req == 6'h00, "R13", "reset irq_req", irq_req, 0);
    endtask

    task automatic t_level();
        irq_pin[0] = 1'b0;
        tick(2);
        chk_flag(0, 1'b0, "R3", "level not yet after 2 edges");
        tick(1);
        chk_flag(0, 1'b1, "R3", "level set after 3 edges");
        svc_ack[0] = 1'b1; tick(1); svc_ack[0] = 1'b0;
        chk_flag(0, 1'b1, "R10", "level ack while pin low");
        irq_pin[0] = 1'b1; tick(3);
        svc_ack[0] = 1'b1; tick(1); svc_ack[0] = 1'b0;
        chk_flag(0, 1'b0, "R10", "level ack with pin high");
    endtask

    task automatic t_falling();
        irq_pin[1] = 1'b0; tick(3);
        chk_flag(1, 1'b1, "R4", "falling edge sets");
        svc_ack[1] = 1'b1; tick(1); svc_ack[1] = 1'b0;
        chk_flag(1, 1'b0, "R9", "edge-mode ack clears");
        irq_pin[1] = 1'b1; tick(4);
        chk_flag(1, 1'b0, "R4", "rising ignored in falling mode");
    endtask

    task automatic t_rising();
        irq_pin[2] = 1'b0; tick(4);
        chk_flag(2, 1'b0, "R5", "falling ignored in rising mode");
        irq_pin[2] = 1'b1; tick(3);
        chk_flag(2, 1'b1, "R5", "rising edge sets");
    endtask

    task automatic t_both();
        irq_pin[3] = 1'b0; tick(3);
        chk_flag(3, 1'b1, "R6", "both mode falling sets");
        reg_rd = 1'b1; tick(1); reg_rd = 1'b0;
        reg_wr = 1'b1; reg_wdata = 8'hF7; tick(1);
        reg_wr = 1'b0; reg_wdata = 8'hFF;
        chk_flag(3, 1'b0, "R8", "read-1 then write-0 clears");
        chk_flag(2, 1'b1, "R8", "unread-authorized bit 2 kept");
        irq_pin[3] = 1'b1; tick(3);
        chk_flag(3, 1'b1, "R6", "both mode rising sets");
        chk(reg_rdata[7:6] == 2'b00, "R1", "reserved bits", reg_rdata[7:6], 0);
        chk(irq_req == reg_rdata[5:0], "R13", "req mirrors flags", irq_req, reg_rdata[5:0]);
    endtask

    task automatic t_write();
        irq_pin[4] = 1'b0; tick(3);
        chk_flag(4, 1'b1, "R4", "line 4 falling sets");
        reg_wr = 1'b1; reg_wdata = 8'h00; tick(1); reg_wr = 1'b0;
        chk_flag(4, 1'b1, "R8", "write 0 without read");
        reg_rd = 1'b1; tick(1); reg_rd = 1'b0;
        reg_wr = 1'b1; reg_wdata = 8'hFF; tick(1); reg_wr = 1'b0;
        chk_flag(4, 1'b1, "R7", "write 1 after read");
        reg_wr = 1'b1; reg_wdata = 8'h00; tick(1); reg_wr = 1'b0;
        chk_flag(4, 1'b1, "R8", "stale read after write");
        reg_rd = 1'b1; tick(1); reg_rd = 1'b0;
        reg_wr = 1'b1; reg_wdata = 8'hEF; tick(1); reg_wr = 1'b0;
        reg_wdata = 8'hFF;
        chk_flag(4, 1'b0, "R8", "fresh read then write 0");
    endtask

    task automatic t_xfer();
        irq_pin[5] = 1'b0; tick(3);
        chk_flag(5, 1'b1, "R11", "line 5 set");
        xfer_dis = 1'b1; xfer_ack[5] = 1'b1; tick(1); xfer_ack[5] = 1'b0;
        chk_flag(5, 1'b1, "R11", "transfer ack with disable high");
        xfer_dis = 1'b0; xfer_ack[5] = 1'b1; tick(1); xfer_ack[5] = 1'b0;
        chk_flag(5, 1'b0, "R11", "transfer ack with disable low");
    endtask

    task automatic t_setwins();
        irq_pin[3] = 1'b0; tick(2);
        svc_ack[3] = 1'b1; tick(1); svc_ack[3] = 1'b0;
        chk_flag(3, 1'b1, "R12", "set beats same-cycle ack");
        svc_ack[3] = 1'b1; tick(1); svc_ack[3] = 1'b0;
        chk_flag(3, 1'b0, "R9", "later ack alone clears");
    endtask

    task automatic t_standby();
        irq_pin[1] = 1'b0; tick(3);
        chk_flag(1, 1'b1, "R4", "line 1 set again");
        hw_standby = 1'b1; tick(1); hw_standby = 1'b0;
        chk(reg_rdata == 8'h00, "R2", "standby wipes", reg_rdata, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        sense_sel = {2'b01, 2'b01, 2'b11, 2'b10, 2'b01, 2'b00};
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_level();
        t_falling();
        t_rising();
        t_both();
        t_write();
        t_xfer();
        t_setwins();
        t_standby();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            summary();
            $finish;
        end
    end
endmodule